// File: doc/BRIEF.md
# Flash Page Staging Buffer

This block holds the bytes that a programming sequencer later commits to a flash data array. A load stream delivers one byte per accepted transfer, addressed by its offset within a page. Because a flash cell can only move from one to zero when programmed, the buffer follows the same rule: a byte starts at all-ones, and every load can only clear bits in it. A load of 8'hFF therefore changes nothing. Each byte carries a flag that records whether it has been loaded since the last clear. The sequencer programs only the flagged bytes, so array bytes behind unflagged slots keep whatever they held before.

The sequencer walks the buffer through a registered read port that returns the byte and its flag. When a program operation ends it pulses `prog_done`. That pulse puts every byte back to 8'hFF and drops every flag. Parameters choose between two layouts. The first is a full-page buffer, where the offset is exactly the buffer index. The second is a half-page buffer for a page twice the buffer size. In that layout the top offset bit picks the half to be programmed and the lower bits pick the byte. A second parameter turns off AND-merging on a reload.

Load stream rules: a transfer happens on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is low exactly while `prog_done` is high. A source that sees `ld_ready` low must hold its offset and data until a later edge accepts them. The read port has no back-pressure: each `rd_en` returns one result on the next cycle.

Top module: `flash_page_stager`

## Requirements
- R1: After reset every byte reads 8'hFF with its loaded flag clear, `loaded_mask` is zero, `ld_ready` is high and `tgt_half` is low.
- R2: An accepted load into an unflagged slot stores the load data and sets that slot's bit in `loaded_mask` on the following cycle.
- R3: With merging enabled, an accepted load into a flagged slot stores the bitwise AND of the held byte and the new byte.
- R4: An accepted load of 8'hFF leaves the stored byte unchanged.
- R5: One cycle after `prog_done` is high, every byte reads 8'hFF, `loaded_mask` is zero and `tgt_half` is low.
- R6: `ld_ready` is low in any cycle where `prog_done` is high. A load offered in that cycle is not taken and leaves no trace after the clear.
- R7: `rd_en` with index `rd_idx` gives `rd_valid` high on the next cycle, with `rd_data` and `rd_loaded` showing that slot as it was before the edge that sampled the request. `rd_valid` is low in every other cycle.
- R8: A slot that has not been loaded since the last clear reads 8'hFF, and both its `rd_loaded` and its `loaded_mask` bit are 0.
- R9: In half-page layout (HALF_PAGE=1) the slot index is offset bits 5:0. Offsets 8'h05 and 8'h45 therefore reach the same slot. `tgt_half` equals offset bit 6 of the most recent accepted load.
- R10: With merging disabled (ALLOW_MERGE=0), a load of any value other than 8'hFF into a flagged slot leaves the stored byte unchanged.
- R11: In full-page layout (HALF_PAGE=0) the offset is 6 bits wide and `tgt_half` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Load transfer offered |
| ld_ready | output | 1 | Buffer accepts a load this cycle |
| ld_offset | input | 6+HALF_PAGE | Byte offset within the page |
| ld_data | input | 8 | Byte to merge into the buffer |
| prog_done | input | 1 | Program finished: reset the buffer |
| rd_en | input | 1 | Sequencer read request |
| rd_idx | input | 6 | Buffer slot to read |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 8 | Byte held in the slot |
| rd_loaded | output | 1 | Slot has been loaded since the last clear |
| loaded_mask | output | 64 | Loaded flag of every slot |
| tgt_half | output | 1 | Half of the page the buffer targets |

## Verification
Both `ld_ready` and `tgt_half`'s reset value are seen in the same cycle as their cause. Stored bytes and `loaded_mask` change on the edge that accepts a load or a clear, and a read result appears one edge after its request. The bench advances its reference model at each rising edge from the inputs it drove half a cycle earlier, then compares every output three nanoseconds later, once the registers have settled and before new inputs are driven. Directed reads raise `rd_en` at a falling edge and check the result at the following falling edge. Two instances share the stimulus, so one sequence covers both the merging half-page layout and the non-merging full-page layout.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t ERASED = '1;
endpackage

// File: rtl/fpb_addr_split.sv
module fpb_addr_split #(
  parameter int IDX_W     = 6,
  parameter int HALF_PAGE = 1
) (
  input  logic [IDX_W+HALF_PAGE-1:0] offset,
  output logic [IDX_W-1:0]           idx,
  output logic                       half
);
  generate
    if (HALF_PAGE != 0) begin : g_half
      // low bits address the slot, the top bit names the half of the page
      assign idx  = offset[IDX_W-1:0];
      assign half = offset[IDX_W];
    end else begin : g_full
      assign idx  = offset[IDX_W-1:0];
      assign half = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fpb_merge.sv
module fpb_merge
  import fpb_pkg::*;
#(
  parameter bit ALLOW_MERGE = 1'b1
) (
  input  byte_t cur,
  input  logic  cur_loaded,
  input  byte_t incoming,
  output byte_t nxt
);
  generate
    if (ALLOW_MERGE) begin : g_and
      // bits only fall, as in the cells; all-ones is a no-op
      assign nxt = cur & incoming;
    end else begin : g_once
      // an unloaded slot is all-ones, so AND is a plain store there
      assign nxt = (!cur_loaded || incoming == ERASED) ? (cur & incoming) : cur;
    end
  endgenerate
endmodule

// File: rtl/fpb_store.sv
module fpb_store
  import fpb_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter bit ALLOW_MERGE = 1'b1,
  localparam int IDX_W      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  byte_t            wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output byte_t            rd_data,
  output logic             rd_loaded,
  output logic [DEPTH-1:0] mask
);
  byte_t            slot_w [DEPTH];
  logic [DEPTH-1:0] flag_w;

  generate
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      byte_t slot_q;
      logic  flag_q;
      byte_t slot_nxt;
      logic  hit;

      assign hit = wr_en && (wr_idx == IDX_W'(gi));

      fpb_merge #(.ALLOW_MERGE(ALLOW_MERGE)) i_merge (
        .cur        (slot_q),
        .cur_loaded (flag_q),
        .incoming   (wr_data),
        .nxt        (slot_nxt)
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_q <= ERASED;
          flag_q <= 1'b0;
        end else if (clr) begin
          slot_q <= ERASED;
          flag_q <= 1'b0;
        end else if (hit) begin
          slot_q <= slot_nxt;
          flag_q <= 1'b1;
        end
      end

      assign slot_w[gi] = slot_q;
      assign flag_w[gi] = flag_q;
    end
  endgenerate

  assign mask = flag_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= ERASED;
      rd_loaded <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data   <= slot_w[rd_idx];
        rd_loaded <= flag_w[rd_idx];
      end
    end
  end
endmodule

// File: rtl/flash_page_stager.sv
module flash_page_stager
  import fpb_pkg::*;
#(
  parameter int BUF_BYTES   = 64,
  parameter int HALF_PAGE   = 1,
  parameter bit ALLOW_MERGE = 1'b1,
  localparam int IDX_W      = $clog2(BUF_BYTES),
  localparam int OFF_W      = IDX_W + HALF_PAGE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid,
  output logic                 ld_ready,
  input  logic [OFF_W-1:0]     ld_offset,
  input  logic [7:0]           ld_data,
  input  logic                 prog_done,
  input  logic                 rd_en,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic                 rd_valid,
  output logic [7:0]           rd_data,
  output logic                 rd_loaded,
  output logic [BUF_BYTES-1:0] loaded_mask,
  output logic                 tgt_half
);
  logic [IDX_W-1:0] ld_idx;
  logic             ld_half;
  logic             take;
  logic             half_q;

  // the clear wins over a load offered in the same cycle
  assign ld_ready = !prog_done;
  assign take     = ld_valid && ld_ready;

  fpb_addr_split #(.IDX_W(IDX_W), .HALF_PAGE(HALF_PAGE)) i_split (
    .offset (ld_offset),
    .idx    (ld_idx),
    .half   (ld_half)
  );

  fpb_store #(.DEPTH(BUF_BYTES), .ALLOW_MERGE(ALLOW_MERGE)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (prog_done),
    .wr_en     (take),
    .wr_idx    (ld_idx),
    .wr_data   (ld_data),
    .rd_en     (rd_en),
    .rd_idx    (rd_idx),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_loaded (rd_loaded),
    .mask      (loaded_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         half_q <= 1'b0;
    else if (prog_done) half_q <= 1'b0;
    else if (take)      half_q <= ld_half;
  end

  assign tgt_half = half_q;
endmodule

// File: rtl/fpb_checker.sv
module fpb_checker #(
  parameter int BUF_BYTES = 64,
  parameter int HALF_PAGE = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ld_valid,
  input logic                 ld_ready,
  input logic                 prog_done,
  input logic                 rd_en,
  input logic                 rd_valid,
  input logic [7:0]           rd_data,
  input logic                 rd_loaded,
  input logic [BUF_BYTES-1:0] loaded_mask,
  input logic                 tgt_half
);
  a_r6_clear_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> !ld_ready);

  a_r5_clear_drops_flags: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (loaded_mask == '0 && !tgt_half));

  a_r2_flags_only_grow: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_done |=> ((loaded_mask & $past(loaded_mask)) == $past(loaded_mask)));

  a_r2_one_flag_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_done |=> ($countones(loaded_mask ^ $past(loaded_mask)) <= 1));

  a_r2_load_leaves_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> (loaded_mask != '0));

  a_r7_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  a_r8_unloaded_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_loaded) |-> (rd_data == 8'hFF));

  generate
    if (HALF_PAGE == 0) begin : g_full
      a_r11_no_half: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_half);
    end
  endgenerate
endmodule

bind flash_page_stager fpb_checker #(.BUF_BYTES(BUF_BYTES), .HALF_PAGE(HALF_PAGE)) i_fpb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ld_valid    (ld_valid),
  .ld_ready    (ld_ready),
  .prog_done   (prog_done),
  .rd_en       (rd_en),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .rd_loaded   (rd_loaded),
  .loaded_mask (loaded_mask),
  .tgt_half    (tgt_half)
);

// File: tb/test_flash_page_stager.sv
`timescale 1ns/1ps
module test_flash_page_stager;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [6:0]  ld_off = '0;
  logic [7:0]  ld_data = '0;
  logic        prog_done = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_idx = '0;

  logic        a_ready, a_rv, a_rl, a_half;
  logic [7:0]  a_rd;
  logic [63:0] a_mask;
  logic        b_ready, b_rv, b_rl, b_half;
  logic [7:0]  b_rd;
  logic [63:0] b_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  flash_page_stager #(.BUF_BYTES(64), .HALF_PAGE(1), .ALLOW_MERGE(1'b1)) i_flash_page_stager (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(a_ready),
    .ld_offset(ld_off), .ld_data(ld_data), .prog_done(prog_done),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(a_rv), .rd_data(a_rd),
    .rd_loaded(a_rl), .loaded_mask(a_mask), .tgt_half(a_half));

  flash_page_stager #(.BUF_BYTES(64), .HALF_PAGE(0), .ALLOW_MERGE(1'b0)) i_flash_page_stager_nm (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(b_ready),
    .ld_offset(ld_off[5:0]), .ld_data(ld_data), .prog_done(prog_done),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(b_rv), .rd_data(b_rd),
    .rd_loaded(b_rl), .loaded_mask(b_mask), .tgt_half(b_half));

  // reference state, kept as plain arrays
  logic [7:0] ma [64];
  logic [7:0] mb [64];
  bit         fa [64];
  bit         fb [64];
  bit         mh;
  bit         e_rv;
  logic [7:0] e_ard, e_brd;
  bit         e_arl, e_brl;

  function automatic logic [7:0] fold(input logic [7:0] old, input bit fl,
                                      input logic [7:0] d, input bit may_and);
    if (d == 8'hFF) return old;
    if (fl && !may_and) return old;
    return old & d;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin
        ma[i] = 8'hFF; mb[i] = 8'hFF; fa[i] = 0; fb[i] = 0;
      end
      mh = 0; e_rv = 0;
    end else begin
      e_rv = rd_en;
      if (rd_en) begin
        e_ard = ma[rd_idx]; e_arl = fa[rd_idx];
        e_brd = mb[rd_idx]; e_brl = fb[rd_idx];
      end
      if (prog_done) begin
        for (int i = 0; i < 64; i++) begin
          ma[i] = 8'hFF; mb[i] = 8'hFF; fa[i] = 0; fb[i] = 0;
        end
        mh = 0;
      end else if (ld_valid) begin
        ma[ld_off[5:0]] = fold(ma[ld_off[5:0]], fa[ld_off[5:0]], ld_data, 1'b1);
        mb[ld_off[5:0]] = fold(mb[ld_off[5:0]], fb[ld_off[5:0]], ld_data, 1'b0);
        fa[ld_off[5:0]] = 1; fb[ld_off[5:0]] = 1;
        mh = ld_off[6];
      end
      #3;
      begin
        logic [63:0] ema, emb;
        for (int i = 0; i < 64; i++) begin ema[i] = fa[i]; emb[i] = fb[i]; end
        chk(a_mask == ema, "R2 mask (merge/half)", 0, 0);
        chk(b_mask == emb, "R2 mask (no-merge/full)", 0, 0);
        chk(a_ready == !prog_done, "R6 ready", a_ready, !prog_done);
        chk(b_ready == !prog_done, "R6 ready nm", b_ready, !prog_done);
        chk(a_half == mh, "R9 tgt_half", a_half, mh);
        chk(b_half == 1'b0, "R11 tgt_half nm", b_half, 0);
        chk(a_rv == e_rv && b_rv == e_rv, "R7 rd_valid", a_rv, e_rv);
        if (e_rv) begin
          chk(a_rd == e_ard && a_rl == e_arl, "R7 read data", a_rd, e_ard);
          chk(b_rd == e_brd && b_rl == e_brl, "R7 read data nm", b_rd, e_brd);
        end
      end
    end
  end

  task automatic load(input logic [6:0] off, input logic [7:0] d);
    ld_valid = 1; ld_off = off; ld_data = d;
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic rd_both(input logic [5:0] idx, input logic [7:0] ea, input bit la,
                         input logic [7:0] eb, input bit lb, input string tag);
    rd_en = 1; rd_idx = idx;
    @(negedge clk);
    rd_en = 0;
    chk(a_rv && a_rd == ea && a_rl == la, {tag, " main"}, a_rd, ea);
    chk(b_rv && b_rd == eb && b_rl == lb, {tag, " nm"}, b_rd, eb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(a_mask == '0 && b_mask == '0, "R1 mask after reset", a_mask[31:0], 0);
    chk(a_ready && !a_half, "R1 ready/half after reset", {a_ready, a_half}, 2);
    rd_both(6'd0, 8'hFF, 0, 8'hFF, 0, "R1 reset byte");
    // R2 first load
    load(7'h03, 8'hA5);
    rd_both(6'd3, 8'hA5, 1, 8'hA5, 1, "R2 first load");
    chk(a_mask[3] && b_mask[3], "R2 mask bit 3", a_mask[3], 1);
    // R3 AND merge; R10 no-merge keeps old
    load(7'h03, 8'h3C);
    rd_both(6'd3, 8'h24, 1, 8'hA5, 1, "R3/R10 reload");
    // R4 all-ones load
    load(7'h03, 8'hFF);
    rd_both(6'd3, 8'h24, 1, 8'hA5, 1, "R4 load FF");
    // R9 half select and alias
    load(7'h45, 8'h0F);
    chk(a_half == 1'b1, "R9 upper half", a_half, 1);
    chk(b_half == 1'b0, "R11 full layout half", b_half, 0);
    load(7'h05, 8'hF3);
    chk(a_half == 1'b0, "R9 lower half", a_half, 0);
    rd_both(6'd5, 8'h03, 1, 8'h0F, 1, "R9/R10 aliased slot");
    // R8 untouched slot
    rd_both(6'd10, 8'hFF, 0, 8'hFF, 0, "R8 unloaded slot");
    chk(!a_mask[10], "R8 mask bit 10", a_mask[10], 0);
    // R6 load colliding with clear; R5 clear result
    load(7'h45, 8'h00);
    prog_done = 1; ld_valid = 1; ld_off = 7'h07; ld_data = 8'h00;
    #1;
    chk(!a_ready && !b_ready, "R6 ready low during clear", a_ready, 0);
    @(negedge clk);
    prog_done = 0; ld_valid = 0;
    chk(a_mask == '0 && b_mask == '0, "R5 mask cleared", a_mask[31:0], 0);
    chk(!a_half, "R5 half cleared", a_half, 0);
    rd_both(6'd7, 8'hFF, 0, 8'hFF, 0, "R6 dropped load");
    rd_both(6'd3, 8'hFF, 0, 8'hFF, 0, "R5 byte erased");
    // mixed traffic against the reference model
    for (int n = 0; n < 400; n++) begin
      ld_valid  = ($urandom_range(0, 2) != 0);
      ld_off    = 7'($urandom_range(0, 127));
      ld_data   = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom | $urandom);
      prog_done = ($urandom_range(0, 24) == 0);
      rd_en     = ($urandom_range(0, 1) != 0);
      rd_idx    = 6'($urandom_range(0, 63));
      @(negedge clk);
    end
    ld_valid = 0; prog_done = 0; rd_en = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule